// File: doc/BRIEF.md
# Programmable Modulus Frequency Divider

This block divides a clock by a programmable integer. A 4-bit down-counter reloads a program value `N` whenever it reaches its terminal state. The same terminal signal drives the counter's load path, so no other control is involved. The block emits one high pulse, one clock wide, per division period. That pulse can serve as a clock enable or as a divided-rate strobe for logic further down.

A parameter selects one of two build variants. The direct variant counts `N` down to 0 and reloads combinationally from the zero decode, which gives a modulus of `N + 1` (1 to 16). The swallowing variant decodes the terminal state one count early into a single flip-flop. That flop drives the load, so one state is removed from every period and the modulus becomes `N` (2 to 15). In both variants the program value is sampled only on the reload edge.

Top module: `pmdiv_top`

## Requirements
- R1: In the first clock cycle after `rst_n` is released, `pulse_o` is high. This first reload loads the current program value.
- R2: In the direct variant, `pulse_o` goes high once every `N + 1` clock cycles for every `N` from 0 to 15.
- R3: In the direct variant with `N = 0`, `pulse_o` stays high in every cycle, which is modulus 1.
- R4: In the swallowing variant, `pulse_o` goes high once every `N` clock cycles for every `N` from 2 to 15.
- R5: In the swallowing variant, program values 0 and 1 are treated as 2, so the period is 2 cycles.
- R6: Whenever the modulus is 2 or more, each pulse lasts exactly one clock cycle.
- R7: The program value is sampled only on the edge that ends a pulse cycle. A change made in the middle of a period leaves that period's length unchanged, and the following period uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_i | input | W (4) | Program value N |
| pulse_o | output | 1 | Divided output pulse, active high, one cycle wide |

## Verification
Every cycle, the assertions check the counter's own motion. Outside a pulse cycle it steps down by exactly one. After a pulse it holds the value that was loaded. Pulses never run into each other unless the loaded value is zero. The swallowing variant never reaches a zero count. The modulus itself can only be seen in the bench's scenarios. These cover a sweep of every program value in both variants, with the pulse pattern compared against the arithmetic period, the reset-release pulse, clamping of low values, and a program change in the middle of a period.

// File: rtl/pmdiv_pkg.sv
// Package: shared types and constants for the programmable divider.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package pmdiv_pkg;

    // Build variant selecting how the terminal state drives the reload
    typedef enum logic {
        DIV_DIRECT  = 1'b0,   // reload from zero decode, modulus N+1
        DIV_SWALLOW = 1'b1    // reload from early-decode flop, modulus N
    } div_mode_e;

    // Smallest modulus the swallowing variant can produce
    localparam int unsigned SWALLOW_FLOOR = 2;

endpackage

// File: rtl/pmdiv_reload.sv
// Module: computes the value the counter loads on a reload edge.
// The direct variant passes the program value through unchanged. The
// swallowing variant raises values below its floor up to the floor.
// Assumes: W is large enough to hold SWALLOW_FLOOR.
module pmdiv_reload
    import pmdiv_pkg::*;
#(
    parameter int unsigned W    = 4,
    parameter div_mode_e   MODE = DIV_DIRECT
) (
    input  logic [W-1:0] prog_i,
    output logic [W-1:0] ld_val_o
);

    localparam logic [W-1:0] FLOOR = W'(SWALLOW_FLOOR);

    generate
        if (MODE == DIV_SWALLOW) begin : g_clamp
            // Clamp so the early decode always has a state to look at
            always_comb ld_val_o = (prog_i < FLOOR) ? FLOOR : prog_i;
        end else begin : g_pass
            // Direct variant accepts the full range
            always_comb ld_val_o = prog_i;
        end
    endgenerate

endmodule

// File: rtl/pmdiv_counter.sv
// Module: loadable down-counter. It loads ld_val_i when load_i is high and
// otherwise decrements by one.
// Assumes: the caller asserts load_i before the count could wrap below zero.
module pmdiv_counter #(
    parameter int unsigned     W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o
);

    // Count register: reset, reload or step down
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= RST_VAL;
        else if (load_i)
            cnt_o <= ld_val_i;
        else
            cnt_o <= cnt_o - W'(1);
    end

endmodule

// File: rtl/pmdiv_top.sv
// Module: programmable modulus frequency divider.
// The terminal-state signal is both the output pulse and the counter's load
// command. The MODE parameter picks between the direct zero decode and an
// early decode registered in one flop (the swallowing variant).
// Assumes: prog_i is synchronous to clk. Reset is synchronous, active low.
module pmdiv_top
    import pmdiv_pkg::*;
#(
    parameter int unsigned W    = 4,
    parameter div_mode_e   MODE = DIV_DIRECT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prog_i,
    output logic         pulse_o
);

    // Reset count puts the block in its terminal state, so the first
    // cycle after reset pulses and loads the program value
    localparam logic [W-1:0] RST_CNT = (MODE == DIV_SWALLOW) ? W'(1) : '0;
    localparam logic [W-1:0] PRE_TC  = W'(SWALLOW_FLOOR);

    logic [W-1:0] ld_val;
    logic [W-1:0] cnt_q;
    logic         tc;

    pmdiv_reload #(.W(W), .MODE(MODE)) u_reload (
        .prog_i   (prog_i),
        .ld_val_o (ld_val)
    );

    pmdiv_counter #(.W(W), .RST_VAL(RST_CNT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tc),
        .ld_val_i (ld_val),
        .cnt_o    (cnt_q)
    );

    generate
        if (MODE == DIV_SWALLOW) begin : g_swallow
            logic early_q;
            // Flag the last state one clock ahead so the load comes from a flop
            always_ff @(posedge clk) begin
                if (!rst_n)
                    early_q <= 1'b1;
                else
                    early_q <= (cnt_q == PRE_TC);
            end
            always_comb tc = early_q;
        end else begin : g_direct
            // Zero decode drives the reload directly
            always_comb tc = (cnt_q == '0);
        end
    endgenerate

    // Terminal state is the divided output
    always_comb pulse_o = tc;

endmodule

// File: rtl/pmdiv_chk.sv
// Module: assertion checker attached to pmdiv_top through bind.
// Assumes: it sees the top's reset, pulse, count and reload value.
module pmdiv_chk
    import pmdiv_pkg::*;
#(
    parameter int unsigned W    = 4,
    parameter div_mode_e   MODE = DIV_DIRECT
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pulse,
    input logic [W-1:0] cnt,
    input logic [W-1:0] ldval
);

    // R2/R4: outside a pulse cycle the count steps down by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> cnt == $past(cnt) - W'(1));

    // R7: after a pulse the counter holds the value sampled on that edge
    p_reload_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> cnt == $past(ldval));

    // R6: a pulse is one cycle wide unless the modulus is one
    p_single_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && ldval != '0) |=> !pulse);

    generate
        if (MODE == DIV_SWALLOW) begin : g_sw
            // R5: the swallowing variant never reaches a zero count
            p_no_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cnt != '0);
        end
    endgenerate

endmodule

bind pmdiv_top pmdiv_chk #(.W(W), .MODE(MODE)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (pulse_o),
    .cnt   (cnt_q),
    .ldval (ld_val)
);

// File: tb/sim_pmdiv_top.sv
// Bench: both variants run side by side on one program input. It sweeps
// every program value and compares each cycle of the pulse train with
// the arithmetic period.
module sim_pmdiv_top;
    import pmdiv_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] prog = 4'd0;
    logic       pd, ps;
    int         errors = 0;
    int         checks = 0;

    always #5 clk = ~clk;

    pmdiv_top #(.W(4), .MODE(DIV_DIRECT))  u0 (.clk(clk), .rst_n(rst_n), .prog_i(prog), .pulse_o(pd));
    pmdiv_top #(.W(4), .MODE(DIV_SWALLOW)) u1 (.clk(clk), .rst_n(rst_n), .prog_i(prog), .pulse_o(ps));

    function automatic int mod_d(int n); return n + 1; endfunction
    function automatic int mod_s(int n); return (n < 2) ? 2 : n; endfunction

    function automatic bit exp_pulse(int i, int m1, int m2, int chg);
        if (i == 0) return 1'b1;
        if (i < m1 || chg == 0) return (i % m1) == 0;
        return ((i - m1) % m2) == 0;
    endfunction

    // Reset with value n, release, then sample len cycles. At cycle chg
    // (when nonzero) switch the program value to n2.
    task automatic run(input int n, input int n2, input int chg, input int len, input string tag);
        int bad_d, bad_s, md2, ms2;
        bad_d = 0; bad_s = 0;
        md2 = mod_d(n2); ms2 = mod_s(n2);
        @(negedge clk); rst_n = 1'b0; prog = 4'(n);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (pd !== 1'b1 || ps !== 1'b1) begin
            errors++;
            $display("FAIL R1 N=%0d first cycle: direct=%b swallow=%b expected 1 1", n, pd, ps);
        end
        for (int i = 0; i < len; i++) begin
            if (i > 0) begin @(negedge clk); #1; end
            if (pd !== exp_pulse(i, mod_d(n), md2, chg)) bad_d++;
            if (ps !== exp_pulse(i, mod_s(n), ms2, chg)) bad_s++;
            if (chg != 0 && i == chg) prog = 4'(n2);
        end
        checks++;
        if (bad_d != 0) begin
            errors++;
            $display("FAIL %s direct N=%0d: %0d mismatched cycles, expected 0 (period %0d)", tag, n, bad_d, mod_d(n));
        end
        checks++;
        if (bad_s != 0) begin
            errors++;
            $display("FAIL %s swallow N=%0d: %0d mismatched cycles, expected 0 (period %0d)", tag, n, bad_s, mod_s(n));
        end
    endtask

    initial begin
        // R2 R4 R6: full sweep of the program values in both variants
        for (int n = 2; n < 16; n++) run(n, n, 0, 3 * (n + 1) + 2, "R2 R4 R6");
        // R3 and R5: N=0 gives continuous pulses direct, period 2 swallowing
        run(0, 0, 0, 12, "R3 R5");
        // R5: N=1 gives period 2 in both variants
        run(1, 1, 0, 12, "R2 R5");
        // R7: change from 10 to 4 in the middle of the first period
        run(10, 4, 3, 40, "R7");
        // R7: change from 3 to 12 while a short period is running
        run(3, 12, 1, 45, "R7");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule